// File: doc/BRIEF.md
# I2C Slave Spike Filter and Stuck-Bus Timeout

This block sits between the raw clock and data pins of an I2C slave and its protocol engine. Each line passes through a two-flop synchronizer and then a stability filter. The filter takes on a new level only after that level has been steady for `FILT_CYC` consecutive clocks. Narrow noise spikes therefore never reach the engine, and the filtered outputs start at logic high, which is the idle bus state.

A watchdog also observes both filtered lines. If either line stays low without a break for the timeout period (nominally 25 ms, given as `CLK_KHZ * TIMEOUT_MS` system clocks), the block issues a one-clock reset pulse to the serial interface and sets a sticky status flag. After it fires, the watchdog stays in a terminal state until both lines are high again. One stuck event therefore gives exactly one pulse. An enable input switches the watchdog off for static or DC operation. While the watchdog is on, this timeout sets the lowest usable SCL frequency. Normal traffic at 100 kHz or 400 kHz keeps each low period far below the timeout.

Top module: `i2c_bus_guard`

## Requirements
- R1: After reset, `scl_o` and `sda_o` are 1, and `bus_rst_o` and `tmo_flag_o` are 0.
- R2: A low pulse on `scl_i` or `sda_i` that lasts fewer than `FILT_CYC` clock edges leaves the matching filtered output at 1 the whole time.
- R3: A level held for at least `FILT_CYC` edges reaches the filtered output. The output changes on the (2+`FILT_CYC`)-th rising edge after the input changes.
- R4: With `tmo_en_i`=1, if `scl_o` stays 0 then `bus_rst_o` pulses high for exactly one cycle, `TO_CYC` cycles after `scl_o` falls.
- R5: A low on `sda_o` alone, with `scl_o` high, starts the same timeout with the same timing.
- R6: While `tmo_en_i`=0, `bus_rst_o` stays 0 however long either line is held low.
- R7: One continuous low event gives only one reset pulse. After both filtered lines return to 1, a new low event can fire again.
- R8: The timeout count restarts whenever both filtered lines are 1. Repeated lows that are each shorter than `TO_CYC` never cause a reset.
- R9: `tmo_flag_o` goes to 1 in the same cycle as `bus_rst_o` and holds until a cycle with `flag_clr_i`=1 and no timeout. If a timeout and a clear land on the same edge, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| tmo_en_i | input | 1 | 1 enables the stuck-low timeout |
| flag_clr_i | input | 1 | Clears the sticky timeout flag |
| scl_o | output | 1 | Filtered SCL |
| sda_o | output | 1 | Filtered SDA |
| bus_rst_o | output | 1 | One-cycle serial interface reset |
| tmo_flag_o | output | 1 | Sticky timeout flag |

## Verification
The timeout event and a software clear of the sticky flag can reach the flag register on the same clock edge. The bench holds SCL low and measures the filtered fall on the output pins. It then raises `flag_clr_i` for exactly the cycle that contains the firing edge. The case passes if `bus_rst_o` and `tmo_flag_o` are both high on the next sample. A later clear given on its own must then drop the flag.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned IDX_SCL   = 0;
  localparam int unsigned IDX_SDA   = 1;

  typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/line_deglitch.sv
module line_deglitch #(
  parameter int unsigned FILT_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end

  // new level accepted only after FILT_CYC equal samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else if (sync_q[1] == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      filt_q <= sync_q[1];
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign line_o = filt_q;

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_q[1]))); // R3
  AST_FILT_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/stuck_low_timer.sv
module stuck_low_timer #(
  parameter int unsigned TO_CYC = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_f_i,
  input  logic sda_f_i,
  input  logic en_i,
  input  logic clr_i,
  output logic bus_rst_o,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] TERM = CW'(TO_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          pulse_q;
  logic          flag_q;
  logic          fire;
  logic          idle;

  assign idle = !en_i || (scl_f_i && sda_f_i);
  assign fire = !idle && !done_q && (cnt_q == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (idle) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (fire) begin
        cnt_q  <= '0;
        done_q <= 1'b1;  // hold until both lines high
      end else if (!done_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (fire)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign bus_rst_o = pulse_q;
  assign flag_o    = flag_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q); // R4
  AST_RST_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> !$past(scl_f_i && sda_f_i)); // R8
  AST_OFF_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pulse_q); // R6
  AST_FLAG_ON_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> flag_q); // R9
  AST_TERM_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !idle) |=> !pulse_q); // R7
endmodule

// File: rtl/i2c_bus_guard.sv
module i2c_bus_guard
  import i2c_guard_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned TIMEOUT_MS = 25,
  parameter int unsigned FILT_CYC   = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tmo_en_i,
  input  logic flag_clr_i,
  output logic scl_o,
  output logic sda_o,
  output logic bus_rst_o,
  output logic tmo_flag_o
);
  localparam int unsigned TO_CYC = CLK_KHZ * TIMEOUT_MS;

  line_vec_t raw;
  line_vec_t filt;

  assign raw[IDX_SCL] = scl_i;
  assign raw[IDX_SDA] = sda_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_deglitch #(.FILT_CYC(FILT_CYC)) i_deglitch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  stuck_low_timer #(.TO_CYC(TO_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (filt[IDX_SCL]),
    .sda_f_i   (filt[IDX_SDA]),
    .en_i      (tmo_en_i),
    .clr_i     (flag_clr_i),
    .bus_rst_o (bus_rst_o),
    .flag_o    (tmo_flag_o)
  );

  assign scl_o = filt[IDX_SCL];
  assign sda_o = filt[IDX_SDA];

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (scl_o && sda_o && !bus_rst_o)); // R1
endmodule

// File: tb/test_i2c_bus_guard.sv
module test_i2c_bus_guard;
  localparam int FILT = 6;
  localparam int KHZ  = 8;
  localparam int TMS  = 25;
  localparam int TO   = KHZ * TMS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, en = 1'b1, clr = 1'b0;
  logic scl_o, sda_o, brst, flag;
  int   tests = 0, fails = 0;

  always #5 clk = ~clk;

  i2c_bus_guard #(.CLK_KHZ(KHZ), .TIMEOUT_MS(TMS), .FILT_CYC(FILT)) i_i2c_bus_guard (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .tmo_en_i(en), .flag_clr_i(clr),
    .scl_o(scl_o), .sda_o(sda_o), .bus_rst_o(brst), .tmo_flag_o(flag));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_low(input bit sda_line);
    for (int i = 0; i < 50; i++) begin
      if ((sda_line ? sda_o : scl_o) == 1'b0) break;
      @(negedge clk);
    end
  endtask

  // negedges from current sample until bus_rst_o seen
  task automatic count_to_rst(output int n);
    n = 0;
    while (!brst && n < 3 * TO) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_pulses(input int cycles, output int p);
    p = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (brst) p++;
    end
  endtask

  task automatic release_all();
    scl_i = 1'b1; sda_i = 1'b1;
    repeat (FILT + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 scl_o", scl_o, 1); chk("R1 sda_o", sda_o, 1);
    chk("R1 bus_rst_o", brst, 0); chk("R1 tmo_flag_o", flag, 0);
  endtask

  task automatic t_spike(input bit sda_line);
    int lows = 0;
    if (sda_line) sda_i = 1'b0; else scl_i = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    if (sda_line) sda_i = 1'b1; else scl_i = 1'b1;
    for (int i = 0; i < FILT + 6; i++) begin
      @(negedge clk);
      if ((sda_line ? sda_o : scl_o) == 1'b0) lows++;
    end
    chk(sda_line ? "R2 sda spike" : "R2 scl spike", lows, 0);
  endtask

  task automatic t_pass(input bit sda_line);
    int n = 0;
    if (sda_line) sda_i = 1'b0; else scl_i = 1'b0;
    do begin
      @(negedge clk);
      n++;
    end while ((sda_line ? sda_o : scl_o) && n < 50);
    chk(sda_line ? "R3 sda latency" : "R3 scl latency", n, 2 + FILT);
    if (sda_line) sda_i = 1'b1; else scl_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(sda_line ? sda_o : scl_o) && n < 50);
    chk("R3 rise latency", n, 2 + FILT);
  endtask

  task automatic t_timeout(input bit sda_line);
    int n, p;
    if (sda_line) sda_i = 1'b0; else scl_i = 1'b0;
    @(negedge clk);
    wait_low(sda_line);
    count_to_rst(n);
    chk(sda_line ? "R5 sda timeout cycles" : "R4 scl timeout cycles", n, TO);
    @(negedge clk);
    chk("R4 pulse one cycle", brst, 0);
    chk("R9 flag set", flag, 1);
    count_pulses(2 * TO, p);
    chk("R7 no refire while stuck", p, 0);
    release_all();
    chk("R9 flag sticky after release", flag, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 flag cleared", flag, 0);
  endtask

  task automatic t_rearm();
    int n;
    scl_i = 1'b0; @(negedge clk); wait_low(1'b0);
    count_to_rst(n);
    chk("R7 second event fires", n, TO);
    release_all();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_disabled();
    int p;
    en = 1'b0;
    scl_i = 1'b0; sda_i = 1'b0;
    count_pulses(3 * TO, p);
    chk("R6 no reset when disabled", p, 0);
    chk("R6 flag stays clear", flag, 0);
    release_all();
    en = 1'b1;
  endtask

  task automatic t_traffic();
    int p = 0, q;
    for (int k = 0; k < 6; k++) begin
      scl_i = 1'b0;
      count_pulses(TO - 20, q); p += q;
      scl_i = 1'b1;
      count_pulses(FILT + 8, q); p += q;
    end
    chk("R8 short lows never reset", p, 0);
  endtask

  task automatic t_set_clr_same();
    scl_i = 1'b0; @(negedge clk); wait_low(1'b0);
    repeat (TO - 1) @(negedge clk);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 reset on collision edge", brst, 1);
    chk("R9 set wins over clear", flag, 1);
    release_all();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 clear alone", flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_spike(1'b0);
    t_spike(1'b1);
    t_pass(1'b0);
    t_pass(1'b1);
    t_timeout(1'b0);
    t_timeout(1'b1);
    t_rearm();
    t_disabled();
    t_traffic();
    t_set_clr_same();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule